// File: doc/BRIEF.md
# UART Transmitter with Line Control

This block turns parallel characters into an asynchronous serial stream. A character is handed over through a valid/ready handshake into a one-entry holding register. From there it moves to a shift register, which sends a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then the stop bits. Each bit lasts a fixed number of baud ticks, 16 by default. The ticks come in on a strobe input that is produced elsewhere.

An 8-bit line control register sets the frame format. It can be written at any time and read back on an output bus. The format is latched when each character starts, so a write takes effect from the next character onward. The register's top bit does nothing inside the block. It is brought out as a select line for an external register decoder, which uses it to choose between the divisor registers and the data registers.

Besides odd and even parity, the block can force the parity bit to a constant mark or space. It can also hold the line in a break condition without losing the character that is waiting.

Top module: `uart_line_tx`

## Requirements
- R1: After reset, the line control register reads 0x00, `txd` is high, `tx_ready` is high and `div_sel` is low.
- R2: A frame has a low start bit followed by the data bits, least significant bit first. Control bits [1:0] set the character length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Every start, data and parity bit lasts TICKS_PER_BIT baud ticks.
- R3: The stop bits drive the line high. With control bit 2 at 0 there is one stop bit. With control bit 2 at 1 there are two stop bits, except for 5-bit characters, which get one and a half. On back-to-back characters, the time from one start edge to the next equals the total frame length.
- R4: Control bit 3 at 0 sends no parity bit. Control bit 3 at 1 inserts a parity bit between the last data bit and the stop bits.
- R5: When parity is on and control bit 5 is 0, control bit 4 at 0 makes the total count of ones in the data bits plus the parity bit odd. Control bit 4 at 1 makes that count even.
- R6: When parity is on and control bit 5 is 1, the parity bit is a constant: 1 when control bit 4 is 0, and 0 when control bit 4 is 1.
- R7: `tx_ready` is high exactly while the holding register is empty. Characters are sent in the order they were accepted. A new frame starts only on an idle line or at the end of the previous frame's stop time.
- R8: While control bit 6 is 1, `txd` is held low and no new frame starts. A character waiting in the holding register stays there and is sent correctly once bit 6 returns to 0.
- R9: `div_sel` follows control bit 7. `lc_q` returns the last value written to the line control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Baud tick strobe, one cycle wide |
| lc_we | input | 1 | Write strobe for the line control register |
| lc_wdata | input | 8 | Value to write into the line control register |
| lc_q | output | 8 | Current contents of the line control register |
| div_sel | output | 1 | Divisor-latch select, driven by control bit 7 |
| tx_data | input | 8 | Character to transmit |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | Holding register is empty and can accept a character |
| txd | output | 1 | Serial output, high when idle |

## Verification
The assertions assume two things about the inputs. First, `tx_valid` is only acted on when `tx_ready` is high. Second, `baud_tick` is a clean strobe, so frame timing depends only on counted ticks. The stimulus keeps `baud_tick` high on every cycle, which makes each bit exactly 16 clocks long. It raises `tx_valid` on a falling clock edge and lowers it one cycle after acceptance. It changes the line control register only between captured frames or while break is held, so no character is cut off in the middle.

// File: rtl/uart_line_tx.sv
module uart_line_tx #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       lc_we,
  input  logic [7:0] lc_wdata,
  output logic [7:0] lc_q,
  output logic       div_sel,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic       txd
);
  localparam int CW = $clog2(2 * TICKS_PER_BIT) + 1;
  localparam logic [CW-1:0] LAST_BIT  = CW'(TICKS_PER_BIT - 1);
  localparam logic [CW-1:0] LAST_1P5  = CW'(TICKS_PER_BIT + TICKS_PER_BIT / 2 - 1);
  localparam logic [CW-1:0] LAST_2    = CW'(2 * TICKS_PER_BIT - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           st;
  logic [7:0]    lcr, hold, shreg;
  logic          hold_full;
  logic [CW-1:0] tcnt, f_stop_last;
  logic [2:0]    bidx, f_nb_m1;
  logic          f_par_en, f_par;
  logic          line;

  wire brk = lcr[6];
  wire [7:0] dmask = 8'hFF >> (2'd3 - lcr[1:0]);
  wire dpar = ^(hold & dmask);
  wire par_bit = lcr[5] ? ~lcr[4] : (lcr[4] ? dpar : ~dpar);
  wire [CW-1:0] stop_last = !lcr[2] ? LAST_BIT : (lcr[1:0] == 2'b00 ? LAST_1P5 : LAST_2);
  wire [CW-1:0] last = (st == S_STOP) ? f_stop_last : LAST_BIT;
  wire bit_end = baud_tick && (tcnt == last);
  wire do_load = hold_full && !brk && (st == S_IDLE || (st == S_STOP && bit_end));

  assign lc_q     = lcr;
  assign div_sel  = lcr[7];
  assign tx_ready = !hold_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr         <= '0;
      hold        <= '0;
      hold_full   <= 1'b0;
      shreg       <= '0;
      st          <= S_IDLE;
      tcnt        <= '0;
      bidx        <= '0;
      f_nb_m1     <= '0;
      f_par_en    <= 1'b0;
      f_par       <= 1'b0;
      f_stop_last <= '0;
    end else begin
      if (lc_we) lcr <= lc_wdata;
      if (do_load) begin
        shreg       <= hold;
        hold_full   <= 1'b0;
        st          <= S_START;
        tcnt        <= '0;
        bidx        <= '0;
        f_nb_m1     <= {1'b1, lcr[1:0]};
        f_par_en    <= lcr[3];
        f_par       <= par_bit;
        f_stop_last <= stop_last;
      end else if (st != S_IDLE && baud_tick) begin
        if (tcnt == last) begin
          tcnt <= '0;
          case (st)
            S_START: st <= S_DATA;
            S_DATA: begin
              shreg <= shreg >> 1;
              if (bidx == f_nb_m1) st <= f_par_en ? S_PAR : S_STOP;
              else bidx <= bidx + 3'd1;
            end
            S_PAR:   st <= S_STOP;
            default: st <= S_IDLE;
          endcase
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
      if (tx_valid && !hold_full) begin
        hold      <= tx_data;
        hold_full <= 1'b1;
      end
    end
  end

  always_comb begin
    case (st)
      S_START: line = 1'b0;
      S_DATA:  line = shreg[0];
      S_PAR:   line = f_par;
      default: line = 1'b1;
    endcase
  end

  assign txd = line & ~brk;

  // R7
  accept_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
  // R7
  no_start_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && hold_full == 1'b0) |=> st != S_START);
  // R8
  break_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk && hold_full) |=> hold_full);
  // R8
  break_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk && st == S_IDLE && !lc_we) |=> st == S_IDLE);
  // R4
  par_only_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PAR) |-> f_par_en);
  // R2
  tick_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && st != S_STOP) |-> tcnt <= LAST_BIT);
endmodule

// File: tb/uart_line_tx_bench.sv
module uart_line_tx_bench;
  logic clk = 0, rst_n = 0, baud_tick = 1, lc_we = 0, tx_valid = 0;
  logic [7:0] lc_wdata = 0, tx_data = 0;
  logic [7:0] lc_q;
  logic div_sel, tx_ready, txd;
  int vecs = 0, errs = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_line_tx u_uart_line_tx (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .lc_we(lc_we),
    .lc_wdata(lc_wdata), .lc_q(lc_q), .div_sel(div_sel), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_lc(input logic [7:0] v);
    @(negedge clk); lc_we = 1; lc_wdata = v;
    @(negedge clk); lc_we = 0;
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk); tx_data = d; tx_valid = 1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk); tx_valid = 0;
  endtask

  task automatic recv(input logic [7:0] lc, output logic [7:0] d, output logic p, output int t0);
    int n = 5 + lc[1:0];
    d = 0; p = 0;
    while (txd) @(negedge clk);
    t0 = cyc;
    repeat (7) @(negedge clk);
    chk(txd == 0, "R2 start", txd, 0);
    for (int i = 0; i < n; i++) begin
      repeat (16) @(negedge clk);
      d[i] = txd;
    end
    if (lc[3]) begin
      repeat (16) @(negedge clk);
      p = txd;
    end
    repeat (16) @(negedge clk);
    chk(txd == 1, "R3 stop high", txd, 1);
  endtask

  function automatic logic exp_par(input logic [7:0] lc, input logic [7:0] d);
    int ones = $countones(d & (8'hFF >> (3 - lc[1:0])));
    if (lc[5]) return ~lc[4];
    if (lc[4]) return ones[0];
    return ~ones[0];
  endfunction

  function automatic int frame_len(input logic [7:0] lc);
    int n = 5 + lc[1:0];
    int stop = !lc[2] ? 16 : (n == 5 ? 24 : 32);
    return 16 * (1 + n + lc[3]) + stop;
  endfunction

  task automatic check_frame(input logic [7:0] lc, input logic [7:0] sent,
                             input logic [7:0] got, input logic p);
    logic [7:0] m = 8'hFF >> (3 - lc[1:0]);
    chk(got == (sent & m), "R2 data", got, sent & m);
    if (lc[3]) begin
      if (lc[5]) chk(p == exp_par(lc, sent), "R6 stick parity", p, exp_par(lc, sent));
      else chk(p == exp_par(lc, sent), "R5 parity", p, exp_par(lc, sent));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; vecs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [7:0] g1, g2;
    logic p1, p2;
    int t1, t2;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(lc_q == 8'h00, "R1 lcr", lc_q, 0);
    chk(txd == 1, "R1 txd", txd, 1);
    chk(tx_ready == 1, "R1 ready", tx_ready, 1);
    chk(div_sel == 0, "R1 div_sel", div_sel, 0);
    rst_n = 1;
    @(negedge clk);

    // R9 divisor select and readback
    wr_lc(8'h80);
    chk(div_sel == 1, "R9 div_sel set", div_sel, 1);
    chk(lc_q == 8'h80, "R9 readback", lc_q, 8'h80);
    wr_lc(8'h00);
    chk(div_sel == 0, "R9 div_sel clear", div_sel, 0);

    // R2..R7 sweep of the low six control bits, back-to-back pairs
    for (int c = 0; c < 64; c++) begin
      logic [7:0] lc = 8'(c);
      logic [7:0] d1 = 8'(c * 37 + 5);
      logic [7:0] d2 = ~d1 ^ 8'(c);
      wr_lc(lc);
      fork
        begin send(d1); send(d2); end
        begin
          recv(lc, g1, p1, t1);
          recv(lc, g2, p2, t2);
        end
      join
      check_frame(lc, d1, g1, p1);
      check_frame(lc, d2, g2, p2);
      // R3 and R7: start-to-start spacing equals the full frame
      chk(t2 - t1 == frame_len(lc), "R3 frame spacing", t2 - t1, frame_len(lc));
      if (!lc[3]) chk(t2 - t1 == frame_len(lc), "R4 no parity slot", t2 - t1, frame_len(lc));
    end
    repeat (64) @(negedge clk);

    // R8 break holds line low and keeps the waiting character
    wr_lc(8'h43);
    chk(txd == 0, "R8 break low", txd, 0);
    send(8'hA5);
    repeat (200) @(negedge clk);
    chk(txd == 0, "R8 break still low", txd, 0);
    chk(tx_ready == 0, "R8 char kept", tx_ready, 0);
    fork
      wr_lc(8'h03);
      recv(8'h03, g1, p1, t1);
    join
    chk(g1 == 8'hA5, "R8 resumed char", g1, 8'hA5);
    chk(tx_ready == 1, "R7 holding drained", tx_ready, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule